// File: doc/BRIEF.md
# SDRAM Data-Path Timing Unit

This unit sits between a memory-command sequencer and the 16-bit data pins of an SDRAM array model. It watches the commands as they are issued: read, write, burst stop and precharge. From those it produces the per-beat array strobes and puts each read word on the data bus exactly the programmed CAS latency after its column access. It also drives the output enable of the bidirectional bus and applies the data mask, with a latency of two cycles on reads and zero cycles on writes. The pad is modelled as separate in and out vectors plus an output enable.

Bursts of 1, 2, 4 or 8 beats end on their own. A full-page burst keeps issuing until another command cuts it. A burst stop, or a precharge that covers the bank being accessed, ends a burst at once. Read words already in flight still drain, so CAS latency minus one words appear after the interrupting cycle. Write beats stop in the interrupting cycle itself. A single-write mode limits every write to one beat and leaves reads at the programmed length. The mode settings are expected to stay fixed while a burst is in progress.

Top module: `sdram_dq_timing`

## Requirements
- R1: In the first cycle after reset is released, rd_valid, dq_oe, arr_rd_req and arr_wr_en are all low.
- R2: cfg_cas_lat holds the CAS latency (values 1, 2 and 3). A read command in cycle c makes rd_valid high in cycle c+CAS latency, and dq_out then carries the arr_rd_data value of cycle c.
- R3: cfg_burst_code 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. A read raises arr_rd_req for that many consecutive cycles starting with the command cycle. rd_valid follows the same pattern delayed by the CAS latency, with dq_out equal to arr_rd_data from the matching beat. Afterwards both return low.
- R4: cfg_burst_code 7 selects a full-page burst, in which beats continue every cycle until a burst stop, a matching precharge or a new read or write ends them.
- R5: When dqm is high in cycle c, dq_oe is low in cycle c+2, and rd_valid is unchanged. dq_oe is never high while rd_valid is low.
- R6: arr_wr_en is low in any cycle in which dqm is high, even when that cycle is a write beat.
- R7: A write command in cycle c produces write beats in cycles c to c+BL-1. In each unmasked beat arr_wr_en is high and arr_wr_data equals dq_in of the same cycle.
- R8: With cfg_single_write high, every write has exactly one beat whatever the burst code. Read bursts keep the programmed length.
- R9: A burst stop (cmd_op 2), or a precharge (cmd_op 3) with cmd_all_banks high or with cmd_bank equal to the bank of the read, in cycle s ends arr_rd_req from cycle s on. rd_valid still goes high in cycles s+1 to s+CAS latency-1 for beats issued before s, and is low after that.
- R10: A precharge with cmd_all_banks low to a bank other than the bank of the active burst leaves the burst unchanged.
- R11: A burst stop or matching precharge in cycle s during a write leaves arr_wr_en low in cycle s and in every later cycle of that burst.
- R12: A read (cmd_op 0) or write (cmd_op 1) issued during a burst ends that burst and starts its own in the same cycle. arr_rd_req and arr_wr_en are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 2 | 0 read, 1 write, 2 burst stop, 3 precharge |
| cmd_bank | input | 1 | Bank of the read, write or precharge |
| cmd_all_banks | input | 1 | Precharge covers every bank |
| cfg_cas_lat | input | 2 | CAS latency, 1 to 3 |
| cfg_burst_code | input | 3 | 0/1/2/3 = 1/2/4/8 beats, 7 = full page |
| cfg_single_write | input | 1 | Writes limited to one beat |
| dqm | input | 1 | Data mask sampled each cycle |
| arr_rd_req | output | 1 | Array read beat this cycle |
| arr_rd_data | input | 16 | Array word for the current read beat |
| arr_wr_en | output | 1 | Write dq_in into the array this cycle |
| arr_wr_data | output | 16 | Data for the array write |
| dq_in | input | 16 | Data bus as seen at the pad input |
| dq_out | output | 16 | Data driven toward the pad |
| dq_oe | output | 1 | Pad output enable |
| rd_valid | output | 1 | A read word occupies the bus slot this cycle |

## Verification
If the read shift register has the wrong depth or tap, rd_valid and dq_out move by whole cycles relative to the read command. That shows at the ports on the first word of any burst. If the beat counter holds the wrong remaining count, arr_rd_req or arr_wr_en stays high one cycle too long or drops one cycle early at the burst end. A wrong bank record or stop decode shows within one cycle of the interrupting command, as strobes that continue or stop when they should not. A wrong stage in the mask delay shows as dq_oe dropping in the wrong cycle, two cycles after dqm is raised.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_STOP  = 2'b10,
    OP_PRECH = 2'b11
  } sdp_op_e;
endpackage

// File: rtl/sdp_delay_line.sv
module sdp_delay_line #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   taps
);
  logic [DEPTH-1:0][W-1:0] taps_n;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_comb taps_n[k] = din;
    end else begin : g_body
      always_comb taps_n[k] = taps[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps[k] <= '0;
      else        taps[k] <= taps_n[k];
    end
  end
endmodule

// File: rtl/sdp_burst_ctl.sv
module sdp_burst_ctl #(
  parameter int CODE_W   = 3,
  parameter int MAX_LOG2 = 3,
  localparam int CNT_W   = MAX_LOG2,
  localparam int LEN_W   = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_rd,
  input  logic              new_wr,
  input  logic              cmd_stop,
  input  logic              cmd_prech,
  input  logic              cmd_all,
  input  logic              cmd_bank,
  input  logic [CODE_W-1:0] cfg_burst_code,
  input  logic              cfg_single_write,
  output logic              rd_beat,
  output logic              wr_beat
);
  localparam logic [CODE_W-1:0] PAGE_CODE = '1;

  logic             act_q, act_n;
  logic             rd_q, rd_n;
  logic             page_q, page_n;
  logic             bank_q, bank_n;
  logic [CNT_W-1:0] left_q, left_n;
  logic             start, hit, cont, upd_en;
  logic [LEN_W-1:0] len, len_m1;

  function automatic logic [LEN_W-1:0] beats_of(input logic [CODE_W-1:0] c);
    if (c <= CODE_W'(MAX_LOG2)) beats_of = LEN_W'(1) << c;
    else                        beats_of = LEN_W'(1);
  endfunction

  always_comb begin
    start   = new_rd | new_wr;
    hit     = act_q & (cmd_stop | (cmd_prech & (cmd_all | (cmd_bank == bank_q))));
    cont    = act_q & ~start & ~hit;
    rd_beat = new_rd | (cont & rd_q);
    wr_beat = new_wr | (cont & ~rd_q);
    len     = (new_wr & cfg_single_write) ? LEN_W'(1) : beats_of(cfg_burst_code);
    len_m1  = len - LEN_W'(1);
    upd_en  = start | hit | cont;

    act_n  = act_q;
    rd_n   = rd_q;
    page_n = page_q;
    bank_n = bank_q;
    left_n = left_q;
    if (start) begin
      rd_n   = new_rd;
      bank_n = cmd_bank;
      page_n = (cfg_burst_code == PAGE_CODE) & ~(new_wr & cfg_single_write);
      left_n = len_m1[CNT_W-1:0];
      act_n  = page_n | (len_m1 != '0);
    end else if (hit) begin
      act_n = 1'b0;
    end else if (cont && !page_q) begin
      left_n = left_q - CNT_W'(1);
      act_n  = (left_q != CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      page_q <= 1'b0;
      bank_q <= 1'b0;
      left_q <= '0;
    end else if (upd_en) begin
      act_q  <= act_n;
      rd_q   <= rd_n;
      page_q <= page_n;
      bank_q <= bank_n;
      left_q <= left_n;
    end
  end
endmodule

// File: rtl/sdram_dq_timing.sv
module sdram_dq_timing #(
  parameter int DATA_W     = 16,
  parameter int MAX_CL     = 3,
  parameter int CL_W       = 2,
  parameter int CODE_W     = 3,
  parameter int MAX_LOG2   = 3,
  parameter int RD_DQM_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_bank,
  input  logic              cmd_all_banks,
  input  logic [CL_W-1:0]   cfg_cas_lat,
  input  logic [CODE_W-1:0] cfg_burst_code,
  input  logic              cfg_single_write,
  input  logic              dqm,
  output logic              arr_rd_req,
  input  logic [DATA_W-1:0] arr_rd_data,
  output logic              arr_wr_en,
  output logic [DATA_W-1:0] arr_wr_data,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rd_valid
);
  import sdp_pkg::*;

  localparam int              PIPE_W = DATA_W + 1;
  localparam logic [CL_W-1:0] CL_TOP = CL_W'(MAX_CL);

  sdp_op_e                        op;
  logic                           new_rd, new_wr, cmd_stop, cmd_prech;
  logic                           rd_beat, wr_beat;
  logic [CL_W-1:0]                lat_idx;
  logic [MAX_CL-1:0][PIPE_W-1:0]  rd_taps;
  logic [RD_DQM_LAT-1:0][0:0]     mask_taps;
  logic                           mask_late;

  always_comb begin
    op        = sdp_op_e'(cmd_op);
    new_rd    = cmd_valid & (op == OP_READ);
    new_wr    = cmd_valid & (op == OP_WRITE);
    cmd_stop  = cmd_valid & (op == OP_STOP);
    cmd_prech = cmd_valid & (op == OP_PRECH);
  end

  sdp_burst_ctl #(
    .CODE_W   (CODE_W),
    .MAX_LOG2 (MAX_LOG2)
  ) u_burst (
    .clk              (clk),
    .rst_n            (rst_n),
    .new_rd           (new_rd),
    .new_wr           (new_wr),
    .cmd_stop         (cmd_stop),
    .cmd_prech        (cmd_prech),
    .cmd_all          (cmd_all_banks),
    .cmd_bank         (cmd_bank),
    .cfg_burst_code   (cfg_burst_code),
    .cfg_single_write (cfg_single_write),
    .rd_beat          (rd_beat),
    .wr_beat          (wr_beat)
  );

  sdp_delay_line #(
    .W     (PIPE_W),
    .DEPTH (MAX_CL)
  ) u_rd_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({rd_beat, arr_rd_data}),
    .taps  (rd_taps)
  );

  sdp_delay_line #(
    .W     (1),
    .DEPTH (RD_DQM_LAT)
  ) u_mask_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (dqm),
    .taps  (mask_taps)
  );

  always_comb begin
    if (cfg_cas_lat == '0)        lat_idx = '0;
    else if (cfg_cas_lat > CL_TOP) lat_idx = CL_TOP - CL_W'(1);
    else                           lat_idx = cfg_cas_lat - CL_W'(1);

    mask_late   = mask_taps[RD_DQM_LAT-1][0];
    rd_valid    = rd_taps[lat_idx][PIPE_W-1];
    dq_out      = rd_taps[lat_idx][DATA_W-1:0];
    dq_oe       = rd_valid & ~mask_late;
    arr_rd_req  = rd_beat;
    arr_wr_en   = wr_beat & ~dqm;
    arr_wr_data = dq_in;
  end
endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
  parameter int CL_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic            cmd_all_banks,
  input logic [CL_W-1:0] cfg_cas_lat,
  input logic            cfg_single_write,
  input logic            dqm,
  input logic            arr_rd_req,
  input logic            arr_wr_en,
  input logic            rd_valid,
  input logic            dq_oe
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd0) |-> (!rd_valid && !dq_oe));

  assert_first_word_cl1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b00 && cfg_cas_lat == CL_W'(1)) |-> ##1 rd_valid);

  assert_first_word_cl2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b00 && cfg_cas_lat == CL_W'(2)) |-> ##2 rd_valid);

  assert_first_word_cl3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b00 && cfg_cas_lat == CL_W'(3)) |-> ##3 rd_valid);

  assert_rd_mask_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && $past(dqm, 2)) |-> !dq_oe);

  assert_oe_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> rd_valid);

  assert_wr_mask_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> !dqm);

  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01 && cfg_single_write)
      |=> (!arr_wr_en || (cmd_valid && cmd_op == 2'b01)));

  assert_stop_cuts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b10) |-> (!arr_rd_req && !arr_wr_en));

  assert_prech_all_cuts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b11 && cmd_all_banks) |-> (!arr_rd_req && !arr_wr_en));

  assert_no_dual_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_rd_req && arr_wr_en));
endmodule

bind sdram_dq_timing sdp_checker #(.CL_W(CL_W)) u_sdp_checker (
  .clk              (clk),
  .rst_n            (rst_n),
  .cmd_valid        (cmd_valid),
  .cmd_op           (cmd_op),
  .cmd_all_banks    (cmd_all_banks),
  .cfg_cas_lat      (cfg_cas_lat),
  .cfg_single_write (cfg_single_write),
  .dqm              (dqm),
  .arr_rd_req       (arr_rd_req),
  .arr_wr_en        (arr_wr_en),
  .rd_valid         (rd_valid),
  .dq_oe            (dq_oe)
);

// File: tb/sdram_dq_timing_bench.sv
`timescale 1ns/1ps
module sdram_dq_timing_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic        cmd_bank;
  logic        cmd_all_banks;
  logic [1:0]  cfg_cas_lat;
  logic [2:0]  cfg_burst_code;
  logic        cfg_single_write;
  logic        dqm;
  logic        arr_rd_req;
  logic [15:0] arr_rd_data;
  logic        arr_wr_en;
  logic [15:0] arr_wr_data;
  logic [15:0] dq_in;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int WIN = 18;
  localparam int NONE = 1000;

  always #5 clk = ~clk;

  sdram_dq_timing u_sdram_dq_timing (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_all_banks(cmd_all_banks), .cfg_cas_lat(cfg_cas_lat),
    .cfg_burst_code(cfg_burst_code), .cfg_single_write(cfg_single_write), .dqm(dqm),
    .arr_rd_req(arr_rd_req), .arr_rd_data(arr_rd_data), .arr_wr_en(arr_wr_en),
    .arr_wr_data(arr_wr_data), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .rd_valid(rd_valid)
  );

  task automatic check(input string req, input string what, input int n,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", req, what, n, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cmd_valid = 1'b0; cmd_op = 2'b00; cmd_bank = 1'b0; cmd_all_banks = 1'b0;
    dqm = 1'b0; arr_rd_data = 16'h0; dq_in = 16'h0;
  endtask

  // itype: 0 none, 1 burst stop, 2 precharge same bank, 3 precharge all, 4 precharge other bank
  task automatic run_scn(input int cas, input int code, input int single, input int is_wr,
                         input int itype, input int s, input int m, input string tag);
    int len, stop, fstop, bend, salt;
    bit cut;
    salt = (cas * 64 + code * 8 + itype) * 32;
    if (is_wr != 0 && single != 0) len = 1;
    else if (code == 7)            len = NONE;
    else                           len = 1 << code;
    cut   = (itype >= 1 && itype <= 3);
    stop  = cut ? s : NONE;
    fstop = (len == NONE && !cut) ? 12 : NONE;
    bend  = len;
    if (stop < bend)  bend = stop;
    if (fstop < bend) bend = fstop;
    @(negedge clk);
    cfg_cas_lat = 2'(cas); cfg_burst_code = 3'(code); cfg_single_write = single[0];
    for (int n = 0; n < WIN; n++) begin
      bit bt, bv, ev, eo, ew, er;
      if (n != 0) @(negedge clk);
      idle_inputs();
      arr_rd_data = 16'(salt + n);
      dq_in = 16'hC000 + 16'(n);
      dqm = (n == m);
      if (n == 0) begin
        cmd_valid = 1'b1; cmd_op = (is_wr != 0) ? 2'b01 : 2'b00;
      end else if (itype != 0 && n == s) begin
        cmd_valid = 1'b1; cmd_op = (itype == 1) ? 2'b10 : 2'b11;
        cmd_bank = (itype == 4); cmd_all_banks = (itype == 3);
      end else if (n == fstop) begin
        cmd_valid = 1'b1; cmd_op = 2'b10;
      end
      #4;
      bt = (n < bend);
      bv = (n >= cas) && ((n - cas) < bend);
      er = (is_wr == 0) && bt;
      ew = (is_wr != 0) && bt && (n != m);
      ev = (is_wr == 0) && bv;
      eo = ev && (n - 2 != m);
      check(tag, "arr_rd_req", n, 16'(arr_rd_req), 16'(er));
      check(tag, "arr_wr_en",  n, 16'(arr_wr_en),  16'(ew));
      check(tag, "rd_valid",   n, 16'(rd_valid),   16'(ev));
      check(tag, "dq_oe",      n, 16'(dq_oe),      16'(eo));
      if (ev) check(tag, "dq_out", n, dq_out, 16'(salt + n - cas));
      if (ew) check(tag, "arr_wr_data", n, arr_wr_data, 16'hC000 + 16'(n));
    end
    @(negedge clk);
    idle_inputs();
  endtask

  // R12: read BL8 at cycle 0, second command at cycle 3 (read or write BL8)
  task automatic run_cut(input int second_wr);
    @(negedge clk);
    cfg_cas_lat = 2'd2; cfg_burst_code = 3'd3; cfg_single_write = 1'b0;
    for (int n = 0; n < 16; n++) begin
      bit er, ew, ev;
      if (n != 0) @(negedge clk);
      idle_inputs();
      if (n == 0) begin cmd_valid = 1'b1; cmd_op = 2'b00; end
      if (n == 3) begin cmd_valid = 1'b1; cmd_op = (second_wr != 0) ? 2'b01 : 2'b00; end
      #4;
      er = (second_wr != 0) ? (n < 3) : (n < 11);
      ew = (second_wr != 0) && n >= 3 && n < 11;
      ev = (second_wr != 0) ? (n >= 2 && n < 5) : (n >= 2 && n < 13);
      check("R12", "arr_rd_req", n, 16'(arr_rd_req), 16'(er));
      check("R12", "arr_wr_en",  n, 16'(arr_wr_en),  16'(ew));
      check("R12", "rd_valid",   n, 16'(rd_valid),   16'(ev));
    end
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int codes[5] = '{0, 1, 2, 3, 7};
    rst_n = 1'b0;
    idle_inputs();
    cfg_cas_lat = 2'd1; cfg_burst_code = 3'd0; cfg_single_write = 1'b0;
    dqm = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    dqm = 1'b0;
    #4;
    check("R1", "rd_valid",   0, 16'(rd_valid),   16'h0);
    check("R1", "dq_oe",      0, 16'(dq_oe),      16'h0);
    check("R1", "arr_rd_req", 0, 16'(arr_rd_req), 16'h0);
    check("R1", "arr_wr_en",  0, 16'(arr_wr_en),  16'h0);

    // Full sweep: CAS latency x burst code x direction x single-write mode
    for (int cas = 1; cas <= 3; cas++)
      for (int ci = 0; ci < 5; ci++)
        for (int wr = 0; wr < 2; wr++)
          for (int sw = 0; sw < 2; sw++)
            run_scn(cas, codes[ci], sw, wr, 0, 0, NONE,
                    (wr != 0) ? ((sw != 0) ? "R8" : "R7") :
                    ((codes[ci] == 7) ? "R4" : "R2,R3"));

    // Truncation: stop, precharge same bank, precharge all, precharge other bank
    for (int cas = 1; cas <= 3; cas++)
      for (int ci = 2; ci < 5; ci++)
        for (int wr = 0; wr < 2; wr++)
          for (int s = 1; s <= 6; s++)
            for (int it = 1; it <= 4; it++)
              run_scn(cas, codes[ci], 0, wr, it, s, NONE,
                      (it == 4) ? "R10" : ((wr != 0) ? "R11" : "R9"));

    // Mask placement across read and write bursts of 8
    for (int cas = 1; cas <= 3; cas++)
      for (int wr = 0; wr < 2; wr++)
        for (int m = 0; m <= 8; m++)
          run_scn(cas, 3, 0, wr, 0, 0, m, (wr != 0) ? "R6" : "R5");

    run_cut(1);
    run_cut(0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule